// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the bus-clock timing of programmed I/O cycles on one ATA channel that serves two drives. Each host read or write runs through three phases: an address setup phase, an active phase in which the read or write strobe is asserted, and a recovery phase in which the strobe is released. When the recovery phase ends, the block raises a one-clock completion pulse and returns to idle.

Each drive has its own timing byte. The upper nibble of that byte gives the active length and the lower nibble gives the recovery length. Address setup comes from 2-bit setup fields. A parameter selects how these fields are used. In per-drive mode, each drive has its own field and the longer of the two setups always applies. In shared mode, a single field serves both drives. All settings are captured when the start request is accepted, so the inputs may change while a cycle is running.

The strobe outputs are active high. The pad logic inverts them to form the bus's low-true strobes.

Top module: `pio_strobe_seq`

## Requirements
- R1: A synchronous active-low reset puts the block in idle on the next clock edge. In idle both strobes, busy and done are low.
- R2: Bits [7:4] of the selected drive's timing byte give the active phase length in clocks. Code 0 means 16 clocks, and codes 1 to 15 mean that many clocks.
- R3: Bits [3:0] of the selected timing byte give the recovery length. Code 0 means 16 clocks, codes 1 to 14 mean code+1 clocks, and code 15 means the minimum of 1 clock.
- R4: A 2-bit setup field gives the setup phase length. Code 01 means 2 clocks, 10 means 3 clocks, 00 means 4 clocks and 11 means 5 clocks.
- R5: In per-drive mode (PER_DRIVE_SETUP=1), every cycle uses the longer of the two decoded setup fields, whichever drive is selected.
- R6: In shared mode (PER_DRIVE_SETUP=0), only setup field A is used, and field B has no effect on any cycle.
- R7: The phases run in the order setup, active, recovery. The read strobe is high only during the active phase of a read (write_i=0), and the write strobe only during the active phase of a write (write_i=1). The other strobe stays low.
- R8: Done is high for exactly one clock, directly after the last recovery clock, and the block is idle on the clock after that.
- R9: Busy is high from the clock after a start is accepted through the done clock, inclusive.
- R10: A start request during a cycle, including its done clock, is ignored. Changes to the drive select, the direction, the timing bytes or the setup fields during a cycle do not alter that cycle.
- R11: drive_sel_i=0 selects drv0_timing_i and drive_sel_i=1 selects drv1_timing_i for the active and recovery lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, accepted only in idle |
| write_i | input | 1 | Direction: 1 for a write, 0 for a read |
| drive_sel_i | input | 1 | Drive addressed by this cycle |
| drv0_timing_i | input | 8 | Drive 0 timing byte: active code [7:4], recovery code [3:0] |
| drv1_timing_i | input | 8 | Drive 1 timing byte: active code [7:4], recovery code [3:0] |
| setup_a_i | input | 2 | Setup field A (drive 0, or shared) |
| setup_b_i | input | 2 | Setup field B (drive 1, per-drive mode only) |
| rd_strobe_o | output | 1 | Read strobe, active high |
| wr_strobe_o | output | 1 | Write strobe, active high |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
A new start request can arrive in the same clock as the completion pulse of the running cycle. A request can also arrive while the drive-select, direction and timing inputs are changing in the middle of a cycle. The bench provokes both cases. In some runs it holds start high through an entire cycle. In other runs it rewrites every setting partway through a cycle. It then judges the result from the measured phase lengths and the strobe direction, which must match the settings captured at the start. It also requires busy to be low in the clock after done, so the done clock cannot have swallowed the held request. Both setup modes are instantiated side by side and given the same stimulus.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int PHASE_MAX = 16;
    localparam int CNT_W     = $clog2(PHASE_MAX + 1);
    localparam int NIB_W     = 4;
    localparam int BYTE_W    = 2 * NIB_W;
    localparam int SETUP_W   = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_RECOVER,
        PH_FINISH
    } phase_e;

    typedef struct packed {
        phase_e phase;
        cnt_t   remain;
        cnt_t   strobe_len;
        cnt_t   recover_len;
        logic   is_write;
    } seq_state_t;

    function automatic cnt_t active_len(input logic [NIB_W-1:0] code);
        active_len = (code == '0) ? cnt_t'(PHASE_MAX) : cnt_t'(code);
    endfunction

    function automatic cnt_t recover_len(input logic [NIB_W-1:0] code);
        if (code == '0)
            recover_len = cnt_t'(PHASE_MAX);
        else if (code == '1)
            recover_len = cnt_t'(1);
        else
            recover_len = cnt_t'(code) + cnt_t'(1);
    endfunction

    function automatic cnt_t setup_len(input logic [SETUP_W-1:0] code);
        case (code)
            2'b01:   setup_len = cnt_t'(2);
            2'b10:   setup_len = cnt_t'(3);
            2'b00:   setup_len = cnt_t'(4);
            default: setup_len = cnt_t'(5);
        endcase
    endfunction

endpackage

// File: rtl/pio_timing_unpack.sv
module pio_timing_unpack
    import pio_seq_pkg::*;
(
    input  logic [BYTE_W-1:0] timing_i,
    output cnt_t              strobe_len_o,
    output cnt_t              recover_len_o
);

    always_comb begin
        strobe_len_o  = active_len(timing_i[BYTE_W-1:NIB_W]);
        recover_len_o = recover_len(timing_i[NIB_W-1:0]);
    end

endmodule

// File: rtl/pio_setup_pick.sv
module pio_setup_pick
    import pio_seq_pkg::*;
#(
    parameter bit PER_DRIVE = 1'b1
) (
    input  logic [SETUP_W-1:0] field_a_i,
    input  logic [SETUP_W-1:0] field_b_i,
    output cnt_t               setup_len_o
);

    cnt_t len_a;

    always_comb len_a = setup_len(field_a_i);

    generate
        if (PER_DRIVE) begin : g_slowest
            cnt_t len_b;
            always_comb begin
                len_b       = setup_len(field_b_i);
                setup_len_o = (len_a > len_b) ? len_a : len_b;
            end
        end else begin : g_shared
            logic unused_field_b;
            always_comb begin
                unused_field_b = ^field_b_i;
                setup_len_o    = len_a;
            end
        end
    endgenerate

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_seq_pkg::*;
#(
    parameter bit PER_DRIVE_SETUP = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               write_i,
    input  logic               drive_sel_i,
    input  logic [BYTE_W-1:0]  drv0_timing_i,
    input  logic [BYTE_W-1:0]  drv1_timing_i,
    input  logic [SETUP_W-1:0] setup_a_i,
    input  logic [SETUP_W-1:0] setup_b_i,
    output logic               rd_strobe_o,
    output logic               wr_strobe_o,
    output logic               busy_o,
    output logic               done_o
);

    localparam int N_DRV = 2;

    logic [BYTE_W-1:0] timing_byte [N_DRV];
    cnt_t              drv_strobe  [N_DRV];
    cnt_t              drv_recover [N_DRV];
    cnt_t              setup_cnt;

    always_comb begin
        timing_byte[0] = drv0_timing_i;
        timing_byte[1] = drv1_timing_i;
    end

    generate
        for (genvar g = 0; g < N_DRV; g++) begin : g_drv
            pio_timing_unpack u_unpack (
                .timing_i      (timing_byte[g]),
                .strobe_len_o  (drv_strobe[g]),
                .recover_len_o (drv_recover[g])
            );
        end
    endgenerate

    pio_setup_pick #(.PER_DRIVE(PER_DRIVE_SETUP)) u_setup (
        .field_a_i   (setup_a_i),
        .field_b_i   (setup_b_i),
        .setup_len_o (setup_cnt)
    );

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase       = PH_SETUP;
                    st_d.remain      = setup_cnt - cnt_t'(1);
                    st_d.strobe_len  = drv_strobe[drive_sel_i];
                    st_d.recover_len = drv_recover[drive_sel_i];
                    st_d.is_write    = write_i;
                end
            end
            PH_SETUP: begin
                if (st_q.remain == '0) begin
                    st_d.phase  = PH_STROBE;
                    st_d.remain = st_q.strobe_len - cnt_t'(1);
                end else begin
                    st_d.remain = st_q.remain - cnt_t'(1);
                end
            end
            PH_STROBE: begin
                if (st_q.remain == '0) begin
                    st_d.phase  = PH_RECOVER;
                    st_d.remain = st_q.recover_len - cnt_t'(1);
                end else begin
                    st_d.remain = st_q.remain - cnt_t'(1);
                end
            end
            PH_RECOVER: begin
                if (st_q.remain == '0) st_d.phase = PH_FINISH;
                else                   st_d.remain = st_q.remain - cnt_t'(1);
            end
            PH_FINISH: st_d.phase = PH_IDLE;
            default:   st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, remain: '0, strobe_len: '0,
                      recover_len: '0, is_write: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy_o      = (st_q.phase != PH_IDLE);
        done_o      = (st_q.phase == PH_FINISH);
        rd_strobe_o = (st_q.phase == PH_STROBE) && !st_q.is_write;
        wr_strobe_o = (st_q.phase == PH_STROBE) &&  st_q.is_write;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !rd_strobe_o && !wr_strobe_o));

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe_o && wr_strobe_o));

    // R7
    strobe_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_o || wr_strobe_o) |-> (busy_o && !done_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    // R7
    strobe_dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_o || wr_strobe_o) |=> $stable(wr_strobe_o) || !(rd_strobe_o || wr_strobe_o));

endmodule

// File: tb/pio_strobe_seq_tb.sv
module pio_strobe_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic       drive_sel_i = 1'b0;
    logic [7:0] drv0_timing_i = 8'h11;
    logic [7:0] drv1_timing_i = 8'h11;
    logic [1:0] setup_a_i = 2'b01;
    logic [1:0] setup_b_i = 2'b01;

    logic [1:0] rd, wr, busy, done;

    int total = 0;
    int bad   = 0;
    int wd_count = 0;

    always #4 clk = ~clk;

    pio_strobe_seq #(.PER_DRIVE_SETUP(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .drive_sel_i(drive_sel_i), .drv0_timing_i(drv0_timing_i),
        .drv1_timing_i(drv1_timing_i), .setup_a_i(setup_a_i), .setup_b_i(setup_b_i),
        .rd_strobe_o(rd[0]), .wr_strobe_o(wr[0]), .busy_o(busy[0]), .done_o(done[0])
    );

    pio_strobe_seq #(.PER_DRIVE_SETUP(1'b0)) u_dut_shared (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .drive_sel_i(drive_sel_i), .drv0_timing_i(drv0_timing_i),
        .drv1_timing_i(drv1_timing_i), .setup_a_i(setup_a_i), .setup_b_i(setup_b_i),
        .rd_strobe_o(rd[1]), .wr_strobe_o(wr[1]), .busy_o(busy[1]), .done_o(done[1])
    );

    function automatic int exp_act(input logic [3:0] c);
        return (c == 4'd0) ? 16 : int'(c);
    endfunction

    function automatic int exp_rec(input logic [3:0] c);
        if (c == 4'd0)  return 16;
        if (c == 4'd15) return 1;
        return int'(c) + 1;
    endfunction

    function automatic int exp_setup(input logic [1:0] c);
        case (c)
            2'b01:   return 2;
            2'b10:   return 3;
            2'b00:   return 4;
            default: return 5;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd_count++;
        if (wd_count > 150000) begin
            check(1'b0, "watchdog", wd_count, 150000);
            summary_and_end();
        end
    end

    // Runs one cycle on both instances and checks every phase length.
    task automatic run_cycle(input logic [7:0] t0, input logic [7:0] t1,
                             input logic [1:0] sa, input logic [1:0] sb,
                             input logic sel, input logic wrt,
                             input bit disturb, input bit hold);
        int  n_set[2], n_act[2], n_rec[2];
        bit  dir_bad[2], busy_bad[2], seen[2], after_ok[2], after_done[2];
        int  e_set[2], e_act, e_rec;
        logic [7:0] tsel;
        tsel     = sel ? t1 : t0;
        e_act    = exp_act(tsel[7:4]);
        e_rec    = exp_rec(tsel[3:0]);
        e_set[0] = (exp_setup(sa) > exp_setup(sb)) ? exp_setup(sa) : exp_setup(sb);
        e_set[1] = exp_setup(sa);
        for (int d = 0; d < 2; d++) begin
            n_set[d] = 0; n_act[d] = 0; n_rec[d] = 0;
            dir_bad[d] = 0; busy_bad[d] = 0; seen[d] = 0; after_ok[d] = 0; after_done[d] = 0;
        end
        @(negedge clk);
        drv0_timing_i = t0; drv1_timing_i = t1; setup_a_i = sa; setup_b_i = sb;
        drive_sel_i = sel; write_i = wrt; start_i = 1'b1;
        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            if (!hold) start_i = 1'b0;
            if (disturb && cyc == 2) begin
                drv0_timing_i = ~t0; drv1_timing_i = ~t1;
                setup_a_i = ~sa; setup_b_i = ~sb;
                drive_sel_i = ~sel; write_i = ~wrt; start_i = 1'b1;
            end
            if (disturb && cyc == 3) start_i = hold;
            for (int d = 0; d < 2; d++) begin
                if (seen[d] && !after_done[d]) begin
                    after_ok[d]   = !busy[d] && !done[d];
                    after_done[d] = 1;
                end else if (!seen[d]) begin
                    if (!busy[d]) busy_bad[d] = 1;
                    if (done[d]) seen[d] = 1;
                    else if (rd[d] || wr[d]) begin
                        n_act[d]++;
                        if (wr[d] != wrt || rd[d] == wrt || n_rec[d] != 0) dir_bad[d] = 1;
                    end else if (n_act[d] == 0) n_set[d]++;
                    else n_rec[d]++;
                end
            end
            if (after_done[0] && after_done[1]) break;
        end
        start_i = 1'b0;
        for (int d = 0; d < 2; d++) begin
            check(n_set[d] == e_set[d], d == 0 ? "R4/R5 setup (per-drive)" : "R4/R6 setup (shared)",
                  n_set[d], e_set[d]);
            check(n_act[d] == e_act, "R2/R11 active length", n_act[d], e_act);
            check(n_rec[d] == e_rec, "R3/R11 recovery length", n_rec[d], e_rec);
            check(!dir_bad[d], "R7 strobe direction/order", dir_bad[d], 0);
            check(!busy_bad[d] && seen[d], "R9 busy through done", busy_bad[d], 0);
            check(after_ok[d], "R8/R10 idle after done", after_ok[d], 1);
        end
        if (hold) begin
            // Held start restarts only from idle; let that cycle drain.
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (!busy[0] && !busy[1]) break;
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy[0] && !rd[0] && !wr[0] && !done[0], "R1 reset idle", busy[0], 0);
        check(!busy[1] && !rd[1] && !wr[1] && !done[1], "R1 reset idle shared", busy[1], 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners: longest cycle, shortest cycle
        run_cycle(8'h00, 8'h55, 2'b11, 2'b01, 1'b0, 1'b1, 0, 0);
        run_cycle(8'h3C, 8'h1F, 2'b01, 2'b01, 1'b1, 1'b0, 0, 0);
        // R5: slower setup on the unselected drive still wins; R6: B ignored
        run_cycle(8'h22, 8'h22, 2'b01, 2'b11, 1'b0, 1'b0, 0, 0);
        run_cycle(8'h4E, 8'h91, 2'b10, 2'b00, 1'b1, 1'b1, 0, 0);
        // R10: settings rewritten mid-cycle and start re-requested
        run_cycle(8'h52, 8'hA7, 2'b00, 2'b10, 1'b0, 1'b1, 1, 0);
        // R10: start held through the done clock
        run_cycle(8'h21, 8'h63, 2'b10, 2'b01, 1'b1, 1'b0, 0, 1);

        for (int i = 0; i < 40; i++) begin
            run_cycle(8'($urandom), 8'($urandom), 2'($urandom), 2'($urandom),
                      1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0);
        end

        // R1: reset in the middle of an active phase
        @(negedge clk);
        drv0_timing_i = 8'h88; setup_a_i = 2'b01; setup_b_i = 2'b01;
        drive_sel_i = 1'b0; write_i = 1'b0; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (3) @(negedge clk);
        check(rd[0] == 1'b1, "R7 read strobe mid-active", rd[0], 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy[0] && !rd[0] && !wr[0] && !done[0], "R1 reset mid-cycle", busy[0], 0);
        check(!busy[1] && !rd[1] && !wr[1] && !done[1], "R1 reset mid-cycle shared", busy[1], 0);
        rst_n = 1'b1;
        @(negedge clk);
        summary_and_end();
    end

endmodule